// File: doc/BRIEF.md
# Platform Interrupt Controller with Claim/Complete

The block gathers level interrupt requests from a set of sources and distributes them to a small number of hart contexts. Every source has a programmable priority. Every context has its own per-source enable bits, its own priority threshold and one external-interrupt output line. Source ID 0 is reserved and never interrupts. The default build has 32 IDs (31 usable sources) and two contexts. The source count can be set as high as 1024 IDs.

Software reaches the block through a single-word register bus. A read of a context's claim/complete word hands over the best eligible pending source in one atomic step, and that source's pending flag is cleared in the same step. The source then stays in service, and its gateway ignores its request line, until the same context writes that ID back to the same word. Once no eligible source remains, the context's line drops.

Top module: `irq_hub`

## Requirements
- R1: After reset all priorities, enable bits and thresholds read as zero, every `irq_out` bit is low, no source is pending or in service, and a claim read returns 0.
- R2: The priority of source n sits at byte address 4*n and keeps its low PRIO_W bits. The entry for source 0 always reads 0 and ignores writes. Reads of any unmapped or unaligned address return 0.
- R3: The enable word for sources 32*w to 32*w+31 of context c sits at 0x2000 + 0x80*c + 4*w, and source n is bit n%32 of that word. The bit for source 0 always reads 0.
- R4: The threshold of context c sits at 0x200000 + 0x1000*c, and its claim/complete word sits 4 bytes higher. The threshold keeps its low PRIO_W bits.
- R5: A pending source is eligible for context c only when it is enabled for c and its priority is strictly greater than c's threshold. `irq_out[c]` is high exactly while c has an eligible pending source, and it changes in the cycle after the state it depends on changes.
- R6: A claim read returns the eligible pending source with the highest priority; on equal priority the lowest ID wins. It returns 0 if nothing is eligible. Read data appears on `bus_rdata` in the cycle after the request.
- R7: A claim clears the source's pending flag and places it in service. While it is in service, its request line does not make it pending again.
- R8: A write to c's claim/complete word with an in-service ID that c enables releases that source. If its request is still high, it becomes pending one cycle later.
- R9: A completion write is ignored when the ID is not in service, is 0 or out of range, or is not enabled for the writing context.
- R10: A source with priority 0 never interrupts any context, even when the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Level request per source ID; bit 0 has no effect |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; must be word-aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after a read |
| irq_out | output | NUM_CTX | External-interrupt line per context |

## Verification
A request sampled at a clock edge sets the pending flag at that edge, and `irq_out` follows in the same cycle. The bench therefore lets two full cycles pass after any change to the request lines before it looks at the interrupt lines or issues a claim. Read data is registered, so every bus task drives on a falling edge and captures `bus_rdata` on the next falling edge. Each task also leaves one idle cycle, which ensures that a source released by a completion is pending again before the next access is decoded. A bench model of the pending and in-service sets predicts every claim result. The same timing applies to the model.

// File: rtl/irq_hub_pkg.sv
// Shared address map constants and access-decode types for irq_hub.
// Assumes byte addresses of at most 32 bits and 32-bit registers.
package irq_hub_pkg;

    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
    localparam int unsigned MAX_IDS    = 1024;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PRIO,
        ACC_EN,
        ACC_THR,
        ACC_CLAIM
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [13:0] ctx;
        logic [9:0]  idx;
    } hub_access_t;

endpackage

// File: rtl/irq_hub_decode.sv
// Turns a bus byte address into a register kind, context and index.
// Assumes NUM_SRC <= 1024 and word-aligned accesses; anything else is ACC_NONE.
module irq_hub_decode
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_CTX = 2,
    parameter int unsigned ADDR_W  = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output hub_access_t       acc
);
    localparam int unsigned EN_WORDS = (NUM_SRC + 31) / 32;

    logic [31:0] a32;
    logic [31:2] en_w;
    logic [31:2] cx_w;

    assign a32  = 32'(addr);
    assign en_w = a32[31:2] - EN_BASE[31:2];
    assign cx_w = a32[31:2] - CTX_BASE[31:2];

    // Classify the address into one register region.
    always_comb begin
        acc = '{kind: ACC_NONE, ctx: '0, idx: '0};
        if (a32[1:0] == 2'b00) begin
            if (a32 < 32'(4 * NUM_SRC)) begin
                acc.kind = ACC_PRIO;
                acc.idx  = 10'(a32[31:2]);
            end else if (a32 >= EN_BASE && a32 < EN_BASE + 32'(NUM_CTX) * EN_STRIDE) begin
                if (32'(en_w[6:2]) < 32'(EN_WORDS)) begin
                    acc.kind = ACC_EN;
                    acc.ctx  = 14'(en_w[31:7]);
                    acc.idx  = 10'(en_w[6:2]);
                end
            end else if (a32 >= CTX_BASE && a32 < CTX_BASE + 32'(NUM_CTX) * CTX_STRIDE) begin
                acc.ctx = 14'(cx_w[31:12]);
                if (cx_w[11:2] == 10'd0)      acc.kind = ACC_THR;
                else if (cx_w[11:2] == 10'd1) acc.kind = ACC_CLAIM;
            end
        end
    end

endmodule

// File: rtl/irq_hub_gate.sv
// Per-source gateway: latches a level request as pending, moves it to
// in-service on a claim and releases it on a completion.
// Assumes at most one claim and one completion per cycle; ID 0 is inert.
module irq_hub_gate #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned ID_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               take_valid,
    input  logic [ID_W-1:0]    take_id,
    input  logic               done_valid,
    input  logic [ID_W-1:0]    done_id,
    output logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] busy
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        if (s == 0) begin : g_null
            assign pend[s] = req[s] & 1'b0;
            assign busy[s] = 1'b0;
        end else begin : g_live
            logic pend_q, busy_q;

            // Pending/in-service state machine of one source.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= 1'b0;
                    busy_q <= 1'b0;
                end else if (take_valid && take_id == ID_W'(s)) begin
                    pend_q <= 1'b0;
                    busy_q <= 1'b1;
                end else begin
                    if (done_valid && done_id == ID_W'(s)) busy_q <= 1'b0;
                    if (req[s] && !busy_q) pend_q <= 1'b1;
                end
            end

            assign pend[s] = pend_q;
            assign busy[s] = busy_q;
        end
    end

endmodule

// File: rtl/irq_hub_pick.sv
// For one context, selects the highest-priority eligible pending source
// (lowest ID on a tie) and raises the context's interrupt line.
// Assumes ID 0 is never pending; a linear scan keeps area minimal.
module irq_hub_pick #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ID_W    = 5
) (
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SRC-1:0]             en,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              thr,
    output logic [ID_W-1:0]                best_id,
    output logic                           irq
);
    logic [PRIO_W-1:0] best_p;

    // Scan sources upward; strict compare keeps the lowest ID on ties.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        irq     = 1'b0;
        for (int s = 1; s < NUM_SRC; s++) begin
            if (pend[s] && en[s] && prio[s] > thr && (!irq || prio[s] > best_p)) begin
                irq     = 1'b1;
                best_p  = prio[s];
                best_id = ID_W'(s);
            end
        end
    end

endmodule

// File: rtl/irq_hub.sv
// Top of the interrupt controller: register file, bus read/write, claim and
// completion control, one gateway bank and one selector per context.
// Assumes one bus access per cycle and registered read data (1-cycle latency).
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_CTX = 2,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ADDR_W  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CTX-1:0] irq_out
);
    localparam int unsigned ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    hub_access_t                          acc;
    logic [NUM_SRC-1:0][PRIO_W-1:0]       prio_q;
    logic [NUM_CTX-1:0][NUM_SRC-1:0]      en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0]       thr_q;
    logic [NUM_SRC-1:0]                   pend_w, busy_w;
    logic [NUM_CTX-1:0][ID_W-1:0]         best_id;
    logic                                 rd_fire, wr_fire;
    logic                                 take_fire, done_fire, done_en;
    logic [ID_W-1:0]                      take_id;
    logic [31:0]                          rd_mux, rdata_q;

    irq_hub_decode #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .acc  (acc)
    );

    assign rd_fire = bus_valid && !bus_write;
    assign wr_fire = bus_valid &&  bus_write;

    // Priority registers; entry 0 stays zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else if (wr_fire && acc.kind == ACC_PRIO) begin
            for (int s = 1; s < NUM_SRC; s++)
                if (acc.idx == 10'(s)) prio_q[s] <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Enable words and thresholds per context; enable bit 0 stays zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            thr_q <= '0;
        end else if (wr_fire) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                if (acc.ctx == 14'(c)) begin
                    if (acc.kind == ACC_THR) thr_q[c] <= bus_wdata[PRIO_W-1:0];
                    if (acc.kind == ACC_EN) begin
                        for (int s = 1; s < NUM_SRC; s++)
                            if (acc.idx == 10'(s / 32)) en_q[c][s] <= bus_wdata[s % 32];
                    end
                end
            end
        end
    end

    // Read-data multiplexer over all register kinds; unmapped reads give 0.
    always_comb begin
        rd_mux = '0;
        unique case (acc.kind)
            ACC_PRIO: begin
                for (int s = 0; s < NUM_SRC; s++)
                    if (acc.idx == 10'(s)) rd_mux = 32'(prio_q[s]);
            end
            ACC_EN: begin
                for (int c = 0; c < NUM_CTX; c++)
                    for (int s = 0; s < NUM_SRC; s++)
                        if (acc.ctx == 14'(c) && acc.idx == 10'(s / 32))
                            rd_mux[s % 32] = en_q[c][s];
            end
            ACC_THR: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (acc.ctx == 14'(c)) rd_mux = 32'(thr_q[c]);
            end
            ACC_CLAIM: begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (acc.ctx == 14'(c)) rd_mux = 32'(best_id[c]);
            end
            default: rd_mux = '0;
        endcase
    end

    // Claim winner of the addressed context and completion legality.
    always_comb begin
        take_id = '0;
        done_en = 1'b0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (acc.ctx == 14'(c)) begin
                take_id = best_id[c];
                for (int s = 1; s < NUM_SRC; s++)
                    if (bus_wdata == 32'(s)) done_en = en_q[c][s];
            end
        end
    end

    assign take_fire = rd_fire && acc.kind == ACC_CLAIM;
    assign done_fire = wr_fire && acc.kind == ACC_CLAIM && done_en;

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    irq_hub_gate #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (src_req),
        .take_valid (take_fire),
        .take_id    (take_id),
        .done_valid (done_fire),
        .done_id    (bus_wdata[ID_W-1:0]),
        .pend       (pend_w),
        .busy       (busy_w)
    );

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irq_hub_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_pick (
            .pend    (pend_w),
            .en      (en_q[c]),
            .prio    (prio_q),
            .thr     (thr_q[c]),
            .best_id (best_id[c]),
            .irq     (irq_out[c])
        );
    end

endmodule

// File: rtl/irq_hub_chk.sv
// Protocol checker for irq_hub, attached by bind. Observes the bus, the
// interrupt lines and the gateway state; it drives nothing.
module irq_hub_chk #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_CTX = 2,
    parameter int unsigned ADDR_W  = 24
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_write,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [NUM_CTX-1:0] irq_out,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] busy
);
    // R1: lines are quiet in the first cycle after reset.
    assert_irq_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> irq_out == '0);

    // R2: the reserved source's priority always reads back zero.
    assert_id0_prio_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == '0) |=> bus_rdata == 32'd0);

    // R7: a source is never pending and in service at once.
    assert_pend_busy_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & busy) == '0);

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        // R6: an idle context's claim returns 0.
        assert_claim_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && !bus_write && !irq_out[c] &&
             bus_addr == ADDR_W'(32'h0020_0004 + 32'(c) * 32'h1000)) |=> bus_rdata == 32'd0);
        // R6: an active context's claim returns a real source.
        assert_claim_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && !bus_write && irq_out[c] &&
             bus_addr == ADDR_W'(32'h0020_0004 + 32'(c) * 32'h1000)) |=> bus_rdata != 32'd0);
    end

    for (genvar s = 1; s < NUM_SRC; s++) begin : g_src
        // R7: entering service consumes the pending flag.
        assert_claim_consumes_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[s]) |-> $fell(pend[s]));
        // R8: service ends only through a bus write.
        assert_release_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(busy[s]) |-> $past(bus_valid && bus_write));
    end

endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .pend      (pend_w),
    .busy      (busy_w)
);

// File: tb/irq_hub_tb_top.sv
// Self-checking bench for irq_hub: directed corner cases then seeded random
// rounds, all predicted by a bench model of pending and in-service sets.
module irq_hub_tb_top;
    localparam int NS = 32;
    localparam int NC = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_req;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [23:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] irq_out;

    int checks = 0;
    int fails  = 0;

    logic [2:0]  mprio [NS];
    logic [31:0] men   [NC];
    logic [2:0]  mthr  [NC];
    logic [31:0] mpend, mbusy, reqv;

    assign src_req = reqv;

    always #2 clk = ~clk;

    irq_hub dut_i (
        .clk (clk), .rst_n (rst_n), .src_req (src_req),
        .bus_valid (bus_valid), .bus_write (bus_write), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_out (irq_out)
    );

    function automatic logic [23:0] a_prio(input int id);       return 24'(id * 4); endfunction
    function automatic logic [23:0] a_en(input int c, input int w); return 24'(32'h2000 + c * 32'h80 + w * 4); endfunction
    function automatic logic [23:0] a_thr(input int c);         return 24'(32'h20_0000 + c * 32'h1000); endfunction
    function automatic logic [23:0] a_clm(input int c);         return 24'(32'h20_0004 + c * 32'h1000); endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    // Model-tracking register writes.
    task automatic set_prio(input int id, input logic [31:0] v);
        wr(a_prio(id), v);
        if (id != 0) mprio[id] = v[2:0];
    endtask
    task automatic set_en(input int c, input logic [31:0] v);
        wr(a_en(c, 0), v);
        men[c] = v & 32'hFFFF_FFFE;
    endtask
    task automatic set_thr(input int c, input logic [31:0] v);
        wr(a_thr(c), v);
        mthr[c] = v[2:0];
    endtask
    task automatic settle();
        repeat (2) @(negedge clk);
        mpend = mpend | (reqv & ~mbusy & 32'hFFFF_FFFE);
    endtask

    function automatic int exp_best(input int c);
        int best = 0;
        logic [2:0] bp = '0;
        for (int s = 1; s < NS; s++)
            if (mpend[s] && men[c][s] && mprio[s] > mthr[c] && (best == 0 || mprio[s] > bp)) begin
                best = s; bp = mprio[s];
            end
        return best;
    endfunction

    task automatic claim(input int c, input string tag);
        logic [31:0] d;
        int e;
        e = exp_best(c);
        rd(a_clm(c), d);
        chk(tag, d, 32'(e));
        if (e != 0) begin mpend[e] = 1'b0; mbusy[e] = 1'b1; end
    endtask

    task automatic complete(input int c, input int id);
        wr(a_clm(c), 32'(id));
        if (id > 0 && id < NS && mbusy[id] && men[c][id]) mbusy[id] = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        for (int c = 0; c < NC; c++) chk(tag, 32'(irq_out[c]), 32'(exp_best(c) != 0));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int ids [6];
        int ctxs [6];
        int n;
        void'($urandom(32'd2024));
        reqv = '0; mpend = '0; mbusy = '0;
        for (int s = 0; s < NS; s++) mprio[s] = '0;
        for (int c = 0; c < NC; c++) begin men[c] = '0; mthr[c] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq after reset", 32'(irq_out), 32'd0);
        rd(a_prio(5), d);  chk("R1 prio reset", d, 32'd0);
        rd(a_en(1, 0), d); chk("R1 enable reset", d, 32'd0);
        rd(a_thr(1), d);   chk("R1 threshold reset", d, 32'd0);
        rd(a_clm(0), d);   chk("R1 claim reset", d, 32'd0);

        // R2: priority storage, width, ID 0 and unmapped space
        set_prio(5, 32'd7);    rd(a_prio(5), d); chk("R2 prio readback", d, 32'd7);
        set_prio(5, 32'hFE);   rd(a_prio(5), d); chk("R2 prio width mask", d, 32'd6);
        set_prio(0, 32'd5);    rd(a_prio(0), d); chk("R2 id0 prio", d, 32'd0);
        rd(24'h80, d);         chk("R2 out of range id", d, 32'd0);
        rd(24'h6, d);          chk("R2 unaligned", d, 32'd0);
        rd(24'h2100, d);       chk("R2 unmapped enable ctx", d, 32'd0);
        set_prio(5, 32'd0);

        // R3: enable layout
        set_en(1, 32'hFFFF_FFFF); rd(a_en(1, 0), d); chk("R3 enable bit0 fixed", d, 32'hFFFF_FFFE);
        set_en(0, 32'h0000_0022); rd(a_en(0, 0), d); chk("R3 enable readback", d, 32'h22);

        // R4: threshold
        set_thr(0, 32'd3);  rd(a_thr(0), d); chk("R4 threshold readback", d, 32'd3);
        set_thr(1, 32'd13); rd(a_thr(1), d); chk("R4 threshold mask", d, 32'd5);
        set_thr(0, 32'd0);  set_thr(1, 32'd0);

        // R10: priority zero never interrupts
        set_en(0, 32'hFFFF_FFFE); set_en(1, 32'h0);
        reqv = 32'h8; settle();
        chk("R10 prio0 irq", 32'(irq_out[0]), 32'd0);
        claim(0, "R10 prio0 claim");

        // R5: strict threshold compare and per-context enable
        set_prio(3, 32'd2); set_thr(0, 32'd2); settle();
        chk("R5 equal to threshold", 32'(irq_out[0]), 32'd0);
        set_thr(0, 32'd1); settle();
        chk("R5 above threshold", 32'(irq_out[0]), 32'd1);
        chk("R5 disabled context", 32'(irq_out[1]), 32'd0);

        // R6: priority order and tie break
        set_prio(4, 32'd5); set_prio(6, 32'd5);
        reqv = 32'h58; settle();
        claim(0, "R6 tie lowest id");

        // R7: gateway masking while in service
        settle();
        claim(0, "R7 masked source skipped");
        claim(0, "R7 next source");
        claim(0, "R7 empty claim");
        settle();
        chk("R7 irq low while in service", 32'(irq_out[0]), 32'd0);

        // R9: ignored completions
        complete(0, 9);  settle();
        claim(0, "R9 non-claimed id ignored");
        complete(1, 4);  settle();
        chk("R9 disabled context completion", 32'(irq_out[0]), 32'd0);
        claim(0, "R9 disabled context completion claim");

        // R8: release then re-pend
        complete(0, 4); settle();
        chk("R8 re-pend irq", 32'(irq_out[0]), 32'd1);
        claim(0, "R8 reclaim");
        reqv = '0;
        complete(0, 4); complete(0, 6); complete(0, 3); settle();
        chk_irq("R8 all released");

        // Random rounds, checked against the model.
        for (int r = 0; r < 150; r++) begin
            for (int k = 0; k < 6; k++) set_prio(1 + ($urandom % (NS - 1)), 32'($urandom % 8));
            for (int c = 0; c < NC; c++) begin
                set_en(c, $urandom);
                set_thr(c, 32'($urandom % 4));
            end
            reqv = $urandom & $urandom;
            settle();
            chk_irq("R5 random irq");
            n = 0;
            for (int c = 0; c < NC; c++) begin
                for (int k = 0; k < 3; k++) begin
                    int e;
                    e = exp_best(c);
                    claim(c, "R6 random claim");
                    if (e != 0) begin ids[n] = e; ctxs[n] = c; n++; end
                end
            end
            for (int k = 0; k < n; k++) complete(ctxs[k], ids[k]);
            settle();
            chk_irq("R8 random after release");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule